// File: doc/BRIEF.md
# Grouped Interrupt Combiner Bank

This block merges level-sensitive interrupt sources into groups of eight and drives one output interrupt line per group toward a parent controller. One bank holds four groups. They share a single 32-bit register window, and group g owns byte lane g (bits 8g to 8g+7) of every register. The global number of a source is its group index times eight plus its bit position within the group. Software services the lowest-numbered active bit in a group first.

Enables are changed only by write-one actions. A write to the set address turns on each enable bit whose data bit is one. A write to the clear address turns off each enable bit whose data bit is one. Zero data bits leave their enables unchanged. Both addresses read back the enable state, so software can save it and restore it later. The status address shows each source ANDed with its enable. A group's output is the registered OR of its eight status bits.

Top module: `irqcmb_bank`

## Requirements
- R1: After reset all enable bits are zero, every register offset reads zero and every `irq_o` bit is low.
- R2: A write at byte offset 0x0 sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged. The new value reads back at 0x0 from the cycle after the write edge.
- R3: A write at byte offset 0x4 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged. A read at 0x4 returns the same enable state as a read at 0x0.
- R4: A read at byte offset 0xC returns the source inputs ANDed bitwise with the enables. Bit 8g+k belongs to source k of group g.
- R5: `irq_o[g]` is high in the cycle after a clock edge at which some source in lane g was active and enabled. Each lane drives only its own output bit.
- R6: `irq_o[g]` goes low one cycle after the last enabled source in lane g drops. A clear write that takes effect at the same edge where a source is active keeps the output low at that edge, and a set write that takes effect at that edge drives it high.
- R7: Byte offset 0x8 always reads zero, and a write there changes no enable bit.
- R8: When `bus_wr_i` is low, or the write address matches no register offset, the enable state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Level-sensitive source inputs, group g on bits 8g..8g+7 |
| bus_wr_i | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr_i | input | 4 | Byte offset within the bank window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 4 | One combined interrupt line per group |

## Verification
The functions that can coincide are an enable write and a change of a source level in the same group, because both reach the output register at the same edge. The bench raises a source on the same falling edge where it presents a set or clear write for that bit. It then checks the output one cycle later. The expected level comes from the enable value the write produces, not from the old one, so a clear gives a low output and a set gives a high one.

// File: rtl/irqcmb_pkg.sv
package irqcmb_pkg;

   // Byte offsets inside one bank window
   localparam logic [3:0] OFS_EN_SET  = 4'h0;
   localparam logic [3:0] OFS_EN_CLR  = 4'h4;
   localparam logic [3:0] OFS_HOLE    = 4'h8;
   localparam logic [3:0] OFS_PENDING = 4'hC;

   typedef enum logic [1:0] {
      RSEL_ENABLE  = 2'd0,
      RSEL_PENDING = 2'd1,
      RSEL_ZERO    = 2'd2
   } rsel_e;

endpackage

// File: rtl/irqcmb_regdec.sv
module irqcmb_regdec
   import irqcmb_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output logic              set_stb,
   output logic              clr_stb,
   output rsel_e             rsel
);

   localparam int OFS_W = 4;

   if (ADDR_W < OFS_W) begin : g_bad_addr
      $error("irqcmb_regdec: ADDR_W must cover the 16-byte window");
   end

   logic hit_set;
   logic hit_clr;
   logic hit_pnd;

   assign hit_set = (addr == ADDR_W'(OFS_EN_SET));
   assign hit_clr = (addr == ADDR_W'(OFS_EN_CLR));
   assign hit_pnd = (addr == ADDR_W'(OFS_PENDING));

   assign set_stb = wr && hit_set;
   assign clr_stb = wr && hit_clr;

   always_comb begin
      if (hit_set || hit_clr)
         rsel = RSEL_ENABLE;
      else if (hit_pnd)
         rsel = RSEL_PENDING;
      else
         rsel = RSEL_ZERO;
   end

endmodule

// File: rtl/irqcmb_enables.sv
module irqcmb_enables #(
   parameter int SRC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_stb,
   input  logic             clr_stb,
   input  logic [SRC_W-1:0] wdata,
   output logic [SRC_W-1:0] en_q,
   output logic [SRC_W-1:0] en_d
);

   logic [SRC_W-1:0] set_bits;
   logic [SRC_W-1:0] clr_bits;

   assign set_bits = set_stb ? wdata : '0;
   assign clr_bits = clr_stb ? wdata : '0;
   assign en_d     = (en_q | set_bits) & ~clr_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else
         en_q <= en_d;
   end

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((en_q & $past(wdata)) == $past(wdata))); // R2
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((en_q & $past(wdata)) == '0)); // R3
   AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(en_q)); // R8

endmodule

// File: rtl/irqcmb_lane.sv
module irqcmb_lane #(
   parameter int GRP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GRP_W-1:0] src,
   input  logic [GRP_W-1:0] en_q,
   input  logic [GRP_W-1:0] en_d,
   output logic [GRP_W-1:0] pending,
   output logic             irq
);

   logic any_next;

   assign pending  = src & en_q;
   assign any_next = |(src & en_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq <= 1'b0;
      else
         irq <= any_next;
   end

   AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      ((|pending) && (en_d == en_q)) |=> irq); // R5
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(|src) |=> !irq); // R6

endmodule

// File: rtl/irqcmb_bank.sv
module irqcmb_bank
   import irqcmb_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int GRP_W      = 8,
   parameter int BUS_W      = 32,
   parameter int ADDR_W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_GROUPS*GRP_W-1:0] src_i,
   input  logic                       bus_wr_i,
   input  logic [ADDR_W-1:0]          bus_addr_i,
   input  logic [BUS_W-1:0]           bus_wdata_i,
   output logic [BUS_W-1:0]           bus_rdata_o,
   output logic [NUM_GROUPS-1:0]      irq_o
);

   localparam int SRC_W = NUM_GROUPS * GRP_W;

   if (SRC_W > BUS_W) begin : g_bad_width
      $error("irqcmb_bank: groups do not fit in one bus word");
   end
   if (NUM_GROUPS < 1 || GRP_W < 1) begin : g_bad_count
      $error("irqcmb_bank: group count and width must be positive");
   end

   logic             set_stb;
   logic             clr_stb;
   rsel_e            rsel;
   logic [SRC_W-1:0] en_q;
   logic [SRC_W-1:0] en_d;
   logic [SRC_W-1:0] pending;
   logic [SRC_W-1:0] wdata_s;

   assign wdata_s = bus_wdata_i[SRC_W-1:0];

   irqcmb_regdec #(.ADDR_W(ADDR_W)) u_dec (
      .wr      (bus_wr_i),
      .addr    (bus_addr_i),
      .set_stb (set_stb),
      .clr_stb (clr_stb),
      .rsel    (rsel)
   );

   irqcmb_enables #(.SRC_W(SRC_W)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (set_stb),
      .clr_stb (clr_stb),
      .wdata   (wdata_s),
      .en_q    (en_q),
      .en_d    (en_d)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lane
      irqcmb_lane #(.GRP_W(GRP_W)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .src     (src_i[g*GRP_W +: GRP_W]),
         .en_q    (en_q[g*GRP_W +: GRP_W]),
         .en_d    (en_d[g*GRP_W +: GRP_W]),
         .pending (pending[g*GRP_W +: GRP_W]),
         .irq     (irq_o[g])
      );
   end

   always_comb begin
      bus_rdata_o = '0;
      unique case (rsel)
         RSEL_ENABLE:  bus_rdata_o = BUS_W'(en_q);
         RSEL_PENDING: bus_rdata_o = BUS_W'(pending);
         default:      bus_rdata_o = '0;
      endcase
   end

   AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i == ADDR_W'(OFS_HOLE)) |-> (bus_rdata_o == '0)); // R7
   AST_OUT_IDLE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (en_d == '0) |=> (irq_o == '0)); // R1

endmodule

// File: tb/irqcmb_bank_test.sv
module irqcmb_bank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        bus_wr_i = 1'b0;
   logic [3:0]  bus_addr_i = '0;
   logic [31:0] bus_wdata_i = '0;
   logic [31:0] bus_rdata_o;
   logic [3:0]  irq_o;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_en = '0;

   always #10 clk = ~clk;

   irqcmb_bank uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_i       (src_i),
      .bus_wr_i    (bus_wr_i),
      .bus_addr_i  (bus_addr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .irq_o       (irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // Present a write on a falling edge; it is applied at the next rising edge.
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
      @(negedge clk);
      bus_wr_i = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr_i = a;
      #1;
      d = bus_rdata_o;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(4'h0, v); check("R1 en set", v, 32'h0);
      rd(4'h4, v); check("R1 en clr", v, 32'h0);
      rd(4'hC, v); check("R1 status", v, 32'h0);
      check("R1 irq", {28'h0, irq_o}, 32'h0);
   endtask

   task automatic t_set();
      logic [31:0] v;
      wr(4'h0, 32'h0000_00A5); exp_en |= 32'h0000_00A5;
      wr(4'h0, 32'h0F00_0000); exp_en |= 32'h0F00_0000;
      rd(4'h0, v); check("R2 set readback", v, exp_en);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      wr(4'h4, 32'h0000_0081); exp_en &= ~32'h0000_0081;
      rd(4'h4, v); check("R3 clr readback", v, exp_en);
      rd(4'h0, v); check("R3 set addr same", v, exp_en);
   endtask

   task automatic t_status();
      logic [31:0] v;
      src_i = 32'hFFFF_FFFF;
      rd(4'hC, v); check("R4 status all", v, exp_en);
      src_i = 32'h0100_0024;
      rd(4'hC, v); check("R4 status mix", v, 32'h0100_0024 & exp_en);
      src_i = '0;
   endtask

   task automatic t_irq();
      @(negedge clk); src_i = 32'h0000_0004;
      @(negedge clk); check("R5 lane0", {28'h0, irq_o}, 32'h1);
      src_i = 32'h0200_0000;
      @(negedge clk); check("R5 lane3", {28'h0, irq_o}, 32'h8);
      src_i = 32'h00FF_FF00;
      @(negedge clk); check("R5 masked lanes", {28'h0, irq_o}, 32'h0);
   endtask

   task automatic t_drop();
      @(negedge clk); src_i = 32'h0000_0004;
      @(negedge clk); check("R6 up", {28'h0, irq_o}, 32'h1);
      src_i = '0;
      @(negedge clk); check("R6 drop", {28'h0, irq_o}, 32'h0);
      // clear write meets an active source at the same edge
      src_i = 32'h0000_0004;
      bus_wr_i = 1'b1; bus_addr_i = 4'h4; bus_wdata_i = 32'h0000_0004;
      exp_en &= ~32'h0000_0004;
      @(negedge clk); bus_wr_i = 1'b0;
      check("R6 clr same edge", {28'h0, irq_o}, 32'h0);
      // set write meets a rising source at the same edge
      src_i = 32'h0000_0400;
      bus_wr_i = 1'b1; bus_addr_i = 4'h0; bus_wdata_i = 32'h0000_0400;
      exp_en |= 32'h0000_0400;
      @(negedge clk); bus_wr_i = 1'b0;
      check("R6 set same edge", {28'h0, irq_o}, 32'h2);
      src_i = '0;
      @(negedge clk);
   endtask

   task automatic t_hole();
      logic [31:0] v;
      wr(4'h8, 32'hFFFF_FFFF);
      rd(4'h8, v); check("R7 hole read", v, 32'h0);
      rd(4'h0, v); check("R7 hole write", v, exp_en);
   endtask

   task automatic t_nowrite();
      logic [31:0] v;
      @(negedge clk);
      bus_addr_i = 4'h0; bus_wdata_i = 32'hFFFF_FFFF;
      @(negedge clk);
      rd(4'h0, v); check("R8 no strobe", v, exp_en);
      wr(4'h2, 32'hFFFF_FFFF);
      rd(4'h0, v); check("R8 odd offset", v, exp_en);
   endtask

   initial begin : watchdog
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set();
      t_clear();
      t_status();
      t_irq();
      t_drop();
      t_hole();
      t_nowrite();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule